// File: doc/BRIEF.md
# Effective Address and Segment Selector

This block forms the byte offset of a memory operand and picks the segment register that the access goes through. Each request carries an optional base register, an optional index register with a scale code, an optional displacement of 8, 16 or 32 bits, an access kind and an optional segment override. The block adds the parts modulo 2^ADDR_W and selects the segment from fixed rules: some access kinds always use one segment, and a base in the stack or frame pointer register moves the default from the data segment to the stack segment.

The result sits in a single output register with a valid/ready handshake, so the block fits between an instruction decoder and an address translation stage. A new request is taken every cycle while the consumer keeps draining. A request that names the stack pointer register as its index is marked with an illegal-encoding flag. The offset and segment are still produced for that request.

Register numbering follows the usual general-register code: code 4 is the stack pointer and code 5 is the frame pointer. Segment identifiers are: 0 extra, 1 code, 2 stack, 3 data, 4 auxiliary F, 5 auxiliary G.

Top module: `agu_seg_sel`

## Requirements
- R1: `out_offset` equals base + index·scale + sign-extended displacement, wrapped to ADDR_W bits. A component whose enable is low, or whose displacement size code is 0, adds zero.
- R2: `scale_code` 0, 1, 2 and 3 multiplies the index by 1, 2, 4 and 8. The scale has no effect when `index_en` is low.
- R3: `disp_size` 1 sign-extends `disp_raw[7:0]` and `disp_size` 2 sign-extends `disp_raw[15:0]`. `disp_size` 3 uses all of `disp_raw`. Raw bits above the selected size have no effect.
- R4: `out_illegal` is 1 exactly when `index_en` is 1 and `index_id` is 4, the stack pointer.
- R5: For `acc_kind` 0 (general data) with override code 6 or 7, the segment is 2 (stack) when `base_en` is 1 and `base_id` is 4 or 5. Otherwise it is 3 (data).
- R6: `acc_kind` 1 (instruction fetch) gives segment 1. `acc_kind` 2 (push/pop) gives segment 2. `acc_kind` 3 (string destination) gives segment 0. For these three kinds the override code and the base register have no effect.
- R7: For `acc_kind` 0, an override code from 0 to 5 is passed out as the segment, whatever the base register.
- R8: While reset is held, `out_valid` is 0 and `in_ready` is 1.
- R9: A request accepted at a clock edge (`in_valid` and `in_ready` both high) shows on the outputs with `out_valid` high right after that edge. The outputs stay unchanged while `out_valid` is high and `out_ready` is low.
- R10: `in_ready` is high whenever `out_ready` is high, so back-to-back requests flow at one per cycle with no bubble. `in_ready` is low while a result is held against `out_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| base_en | input | 1 | Base component present |
| base_id | input | 3 | Base register code |
| base_val | input | ADDR_W | Base register value |
| index_en | input | 1 | Index component present |
| index_id | input | 3 | Index register code |
| index_val | input | ADDR_W | Index register value |
| scale_code | input | 2 | Index multiplier select (1,2,4,8) |
| disp_size | input | 2 | Displacement size: none, 8, 16, 32 bits |
| disp_raw | input | ADDR_W | Raw displacement bits |
| seg_ovr | input | 3 | Override segment code, 6/7 = none |
| acc_kind | input | 2 | Access kind: data, fetch, push/pop, string destination |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_offset | output | ADDR_W | Computed offset |
| out_seg | output | 3 | Selected segment identifier |
| out_illegal | output | 1 | Stack pointer used as index |

## Verification
The bench uses the default parameters, ADDR_W = 32 with 3-bit register codes. At this size the segment choice can be swept exhaustively over every access kind, override code, base presence and base register code, and the illegal flag over every index code and presence. Offsets are swept over all presence combinations, scale codes and displacement sizes, using operands picked to hit wrap-around and sign boundaries. Expected sums are computed arithmetically in the bench. Stall and drain sequences exercise the hold and no-bubble behaviour of the output register.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam int REG_ID_W = 3;
  localparam int SEG_W    = 3;

  localparam logic [REG_ID_W-1:0] STACK_PTR_ID = 3'd4;
  localparam logic [REG_ID_W-1:0] FRAME_PTR_ID = 3'd5;

  localparam logic [SEG_W-1:0] SEG_EXTRA = 3'd0;
  localparam logic [SEG_W-1:0] SEG_CODE  = 3'd1;
  localparam logic [SEG_W-1:0] SEG_STACK = 3'd2;
  localparam logic [SEG_W-1:0] SEG_DATA  = 3'd3;
  localparam logic [SEG_W-1:0] SEG_LAST  = 3'd5;

  typedef enum logic [1:0] {
    ACC_DATA    = 2'd0,
    ACC_FETCH   = 2'd1,
    ACC_STACK   = 2'd2,
    ACC_STR_DST = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_8    = 2'd1,
    DISP_16   = 2'd2,
    DISP_FULL = 2'd3
  } disp_e;

endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              base_en,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              index_en,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [1:0]        scale_code,
  input  logic [1:0]        disp_size,
  input  logic [ADDR_W-1:0] disp_raw,
  output logic [ADDR_W-1:0] offset
);

  localparam int B8  = 8;
  localparam int B16 = 16;

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] disp_term;

  // Absent components contribute zero.
  always_comb begin
    base_term  = base_en  ? base_val : '0;
    index_term = index_en ? (index_val << scale_code) : '0;
  end

  // Displacement sign extension by size code.
  always_comb begin
    unique case (disp_e'(disp_size))
      DISP_8:    disp_term = {{(ADDR_W-B8){disp_raw[B8-1]}},   disp_raw[B8-1:0]};
      DISP_16:   disp_term = {{(ADDR_W-B16){disp_raw[B16-1]}}, disp_raw[B16-1:0]};
      DISP_FULL: disp_term = disp_raw;
      default:   disp_term = '0;
    endcase
  end

  // Adder wraps modulo 2^ADDR_W.
  assign offset = base_term + index_term + disp_term;

endmodule

// File: rtl/seg_select.sv
module seg_select
  import agu_pkg::*;
(
  input  logic [1:0]          acc_kind,
  input  logic [SEG_W-1:0]    seg_ovr,
  input  logic                base_en,
  input  logic [REG_ID_W-1:0] base_id,
  output logic [SEG_W-1:0]    seg
);

  logic stack_base;
  logic ovr_valid;
  logic [SEG_W-1:0] dflt_seg;

  always_comb begin
    stack_base = base_en && ((base_id == STACK_PTR_ID) || (base_id == FRAME_PTR_ID));
    ovr_valid  = (seg_ovr <= SEG_LAST);
    dflt_seg   = stack_base ? SEG_STACK : SEG_DATA;
  end

  // Fixed-segment access kinds ignore the override.
  always_comb begin
    unique case (access_e'(acc_kind))
      ACC_FETCH:   seg = SEG_CODE;
      ACC_STACK:   seg = SEG_STACK;
      ACC_STR_DST: seg = SEG_EXTRA;
      default:     seg = ovr_valid ? seg_ovr : dflt_seg;
    endcase
  end

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
  parameter int PAY_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);

  logic             vld_q, vld_d;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic             take;

  always_comb begin
    in_ready = !vld_q || out_ready;
    take     = in_valid && in_ready;
    vld_d    = take || (vld_q && !out_ready);
    pay_d    = take ? in_pay : pay_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) pay_q <= pay_d;
    end
  end

  assign out_valid = vld_q;
  assign out_pay   = pay_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/agu_seg_sel.sv
module agu_seg_sel
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              base_en,
  input  logic [2:0]        base_id,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              index_en,
  input  logic [2:0]        index_id,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [1:0]        scale_code,
  input  logic [1:0]        disp_size,
  input  logic [ADDR_W-1:0] disp_raw,
  input  logic [2:0]        seg_ovr,
  input  logic [1:0]        acc_kind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_offset,
  output logic [2:0]        out_seg,
  output logic              out_illegal
);

  localparam int PAY_W = ADDR_W + SEG_W + 1;

  logic [ADDR_W-1:0] calc_offset;
  logic [SEG_W-1:0]  calc_seg;
  logic              calc_illegal;
  logic [PAY_W-1:0]  calc_pay;
  logic [PAY_W-1:0]  held_pay;

  ea_offset_calc #(.ADDR_W(ADDR_W)) i_offset (
    .base_en    (base_en),
    .base_val   (base_val),
    .index_en   (index_en),
    .index_val  (index_val),
    .scale_code (scale_code),
    .disp_size  (disp_size),
    .disp_raw   (disp_raw),
    .offset     (calc_offset)
  );

  seg_select i_seg (
    .acc_kind (acc_kind),
    .seg_ovr  (seg_ovr),
    .base_en  (base_en),
    .base_id  (base_id),
    .seg      (calc_seg)
  );

  assign calc_illegal = index_en && (index_id == STACK_PTR_ID);
  assign calc_pay     = {calc_illegal, calc_seg, calc_offset};

  ea_out_stage #(.PAY_W(PAY_W)) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pay    (calc_pay),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pay   (held_pay)
  );

  assign out_offset  = held_pay[ADDR_W-1:0];
  assign out_seg     = held_pay[ADDR_W+SEG_W-1:ADDR_W];
  assign out_illegal = held_pay[PAY_W-1];

  a_r4_stack_index: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && index_en && index_id == STACK_PTR_ID) |=> out_illegal);

  a_r6_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_kind == ACC_FETCH) |=> (out_seg == SEG_CODE));

  a_r6_push_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_kind == ACC_STACK) |=> (out_seg == SEG_STACK));

  a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_kind == ACC_DATA && seg_ovr <= SEG_LAST)
      |=> (out_seg == $past(seg_ovr)));

  a_r1_no_parts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !base_en && !index_en && disp_size == DISP_NONE)
      |=> (out_offset == '0));

endmodule

// File: tb/test_agu_seg_sel.sv
module test_agu_seg_sel;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_ready;
  logic              base_en, index_en;
  logic [2:0]        base_id, index_id, seg_ovr, out_seg;
  logic [ADDR_W-1:0] base_val, index_val, disp_raw, out_offset;
  logic [1:0]        scale_code, disp_size, acc_kind;
  logic              out_valid, out_ready, out_illegal;

  int n_chk = 0;
  int n_bad = 0;

  logic              pend = 1'b0;
  logic [ADDR_W-1:0] e_off;
  logic [2:0]        e_seg;
  logic              e_ill;
  string             e_tag;

  always #(CLK_P/2) clk = ~clk;

  agu_seg_sel #(.ADDR_W(ADDR_W)) i_agu_seg_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_en(base_en), .base_id(base_id), .base_val(base_val),
    .index_en(index_en), .index_id(index_id), .index_val(index_val),
    .scale_code(scale_code), .disp_size(disp_size), .disp_raw(disp_raw),
    .seg_ovr(seg_ovr), .acc_kind(acc_kind), .out_valid(out_valid),
    .out_ready(out_ready), .out_offset(out_offset), .out_seg(out_seg),
    .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic ok, input string got, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %s expected %s", tag, got, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ref_offset(
      logic be, logic [ADDR_W-1:0] bv, logic ie, logic [ADDR_W-1:0] iv,
      logic [1:0] sc, logic [1:0] ds, logic [ADDR_W-1:0] dr);
    longint s;
    longint mult;
    longint d;
    mult = longint'(1) << sc;
    case (ds)
      2'd1:    d = longint'($signed(dr[7:0]));
      2'd2:    d = longint'($signed(dr[15:0]));
      2'd3:    d = longint'($signed(dr));
      default: d = 0;
    endcase
    s = (be ? longint'($signed(bv)) : 0) + (ie ? longint'($signed(iv)) * mult : 0) + d;
    return s[ADDR_W-1:0];
  endfunction

  function automatic logic [2:0] ref_seg(logic [1:0] ak, logic [2:0] ov, logic be, logic [2:0] bid);
    if (ak == 2'd1) return 3'd1;
    if (ak == 2'd2) return 3'd2;
    if (ak == 2'd3) return 3'd0;
    if (ov < 3'd6) return ov;
    if (be && (bid == 3'd4 || bid == 3'd5)) return 3'd2;
    return 3'd3;
  endfunction

  task automatic check_prev();
    check({e_tag, " valid"}, out_valid === 1'b1, $sformatf("%b", out_valid), "1");
    check({e_tag, " offset"}, out_offset === e_off, $sformatf("%h", out_offset), $sformatf("%h", e_off));
    check({e_tag, " seg"}, out_seg === e_seg, $sformatf("%0d", out_seg), $sformatf("%0d", e_seg));
    check({e_tag, " illegal"}, out_illegal === e_ill, $sformatf("%b", out_illegal), $sformatf("%b", e_ill));
  endtask

  // Streaming send with out_ready held high: previous result is checked at the
  // same negedge a new request is driven (R10 no-bubble).
  task automatic send(input logic be, input logic [2:0] bid, input logic [ADDR_W-1:0] bv,
                      input logic ie, input logic [2:0] iid, input logic [ADDR_W-1:0] iv,
                      input logic [1:0] sc, input logic [1:0] ds, input logic [ADDR_W-1:0] dr,
                      input logic [2:0] ov, input logic [1:0] ak, input string tag);
    @(negedge clk);
    if (pend) begin
      check_prev();
      check("R10 ready while streaming", in_ready === 1'b1, $sformatf("%b", in_ready), "1");
    end
    in_valid = 1'b1; base_en = be; base_id = bid; base_val = bv;
    index_en = ie; index_id = iid; index_val = iv; scale_code = sc;
    disp_size = ds; disp_raw = dr; seg_ovr = ov; acc_kind = ak;
    e_off = ref_offset(be, bv, ie, iv, sc, ds, dr);
    e_seg = ref_seg(ak, ov, be, bid);
    e_ill = ie && (iid == 3'd4);
    e_tag = tag;
    pend  = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check_prev();
    in_valid = 1'b0;
    pend = 1'b0;
    @(negedge clk);
    check("R9 drained", out_valid === 1'b0, $sformatf("%b", out_valid), "0");
  endtask

  function automatic logic [ADDR_W-1:0] pick(int k, int which);
    case (which)
      0: case (k) 0: return 32'h0000_0000; 1: return 32'hFFFF_FFFF; 2: return 32'h8000_0000; default: return 32'h1234_5678; endcase
      1: case (k) 0: return 32'h7FFF_FFFF; 1: return 32'h0000_0003; 2: return 32'hFFFF_FFF0; default: return 32'h2000_0001; endcase
      default: case (k) 0: return 32'h5555_0080; 1: return 32'hABCD_7FFF; 2: return 32'h0000_8000; default: return 32'hFFFF_FF7F; endcase
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    base_en = 0; base_id = 0; base_val = 0; index_en = 0; index_id = 0; index_val = 0;
    scale_code = 0; disp_size = 0; disp_raw = 0; seg_ovr = 3'd7; acc_kind = 0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", out_valid === 1'b0, $sformatf("%b", out_valid), "0");
    check("R8 reset ready", in_ready === 1'b1, $sformatf("%b", in_ready), "1");
    rst_n = 1'b1;

    // R5 R6 R7: exhaustive segment selection sweep.
    for (int ak = 0; ak < 4; ak++)
      for (int ov = 0; ov < 8; ov++)
        for (int be = 0; be < 2; be++)
          for (int bid = 0; bid < 8; bid++)
            send(be[0], bid[2:0], 32'h100, 1'b0, 3'd0, 32'h0, 2'd0, 2'd0, 32'h0,
                 ov[2:0], ak[1:0], (ak != 0) ? "R6 fixed segment" : (ov < 6) ? "R7 override" : "R5 default segment");
    flush();

    // R4: illegal flag over every index code and presence.
    for (int ie = 0; ie < 2; ie++)
      for (int iid = 0; iid < 8; iid++)
        send(1'b1, 3'd0, 32'h40, ie[0], iid[2:0], 32'h10, 2'd1, 2'd0, 32'h0, 3'd7, 2'd0, "R4 illegal index");
    flush();

    // R1 R2 R3: offset sweep over presence, scale, displacement size and operands.
    for (int pr = 0; pr < 8; pr++)
      for (int sc = 0; sc < 4; sc++)
        for (int ds = 0; ds < 4; ds++)
          for (int k = 0; k < 4; k++)
            send(pr[0], 3'd1, pick(k, 0), pr[1], 3'd2, pick((k + sc) % 4, 1), sc[1:0],
                 pr[2] ? ds[1:0] : 2'd0, pick((k + ds) % 4, 2), 3'd7, 2'd0,
                 (ds == 1 || ds == 2) ? "R3 displacement" : (pr[1] ? "R2 scale" : "R1 offset sum"));
    flush();

    // R9 R10: hold under back-pressure, then drain into the next request.
    out_ready = 1'b0;
    send(1'b1, 3'd5, 32'h0000_1000, 1'b1, 3'd3, 32'h4, 2'd3, 2'd1, 32'h0000_00F0, 3'd7, 2'd0, "R9 held result");
    @(negedge clk);
    check("R10 stalled ready", in_ready === 1'b0, $sformatf("%b", in_ready), "0");
    in_valid = 1'b1; base_val = 32'h0000_2000; acc_kind = 2'd3; seg_ovr = 3'd4;
    repeat (2) begin
      @(negedge clk);
      check_prev();
      check("R10 stalled ready", in_ready === 1'b0, $sformatf("%b", in_ready), "0");
    end
    out_ready = 1'b1;
    #1;
    check("R10 ready on drain", in_ready === 1'b1, $sformatf("%b", in_ready), "1");
    e_off = ref_offset(1'b1, 32'h0000_2000, 1'b1, 32'h4, 2'd3, 2'd1, 32'h0000_00F0);
    e_seg = 3'd0;
    e_ill = 1'b0;
    e_tag = "R9 next after drain";
    flush();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule